// File: doc/BRIEF.md
# Five-Level Hybrid Inverter PWM Modulator

This block converts a signed, sampled modulation value into the eight gate commands of one phase of a five-level inverter. The inverter combines neutral-point clamping with flying capacitors. The gates form two groups of four. The low-frequency group follows the sign of the modulation value. It selects which half of the bridge conducts and changes state only when the sign changes. The high-frequency group comes from two switching cells. Each cell compares a rectified duty value against its own triangular carrier. The two carriers have the same amplitude and are 180 degrees apart. Each active cell adds one half-step of output voltage. Across the eight switching states this gives five output levels.

An outside current controller supplies the modulation value. The block asks for a new sample at every carrier peak and every carrier valley, which is twice per carrier period. It loads the value only at those instants. The two carriers are shifted against each other. For this reason the single-cell states that produce the half-level alternate between cell A and cell B. The flying capacitors therefore charge and discharge in turn, and they stay balanced without a separate control loop. Every complementary gate pair turns over with a dead time that is set in clock cycles. No gate turns on until a first sample has been loaded.

Top module: `fivelevel_mod`

## Requirements
- R1: After reset, all eight gate outputs stay low until a modulation sample has been loaded, however long the valid input stays low.
- R2: The carrier counts 0 up to CMAX = 2**CAR_BITS and back down, so one period is 2*CMAX cycles. `sample_req_o` is a one-cycle pulse at each peak and each valley, so pulses come exactly CMAX cycles apart.
- R3: A sample is loaded only in a cycle where `mod_valid_i` and `sample_req_o` are both high. A valid strobe in any other cycle has no effect on the gates, and neither does a change of `mod_i` while valid is low.
- R4: For a loaded value with sign bit 0 (zero counts as positive), `lf_gate_o` settles to 4'b0011. For sign bit 1 it settles to 4'b1100.
- R5: The duty value is d = min(CMAX, (|m| * index) >> (MW+IW-2-CAR_BITS)), where m is two's complement with MW bits and index is unsigned with IW bits. For 0 < d < CMAX and dead-time gap g, each cell's upper gate (`hf_gate_o[0]` for cell A, `hf_gate_o[2]` for cell B) is on for 2d-1-g cycles per carrier period. Its lower gate (`hf_gate_o[1]`, `hf_gate_o[3]`) is on for 2*CMAX-2d+1-g cycles per period.
- R6: When d reaches CMAX because of saturation, the upper gates stay on for the whole period and the lower gates stay off. When d = 0, the lower gates stay on for the whole period and the upper gates stay off.
- R7: Cell B's carrier is the mirror, CMAX minus cell A's carrier. For d below CMAX/2, cell A's and cell B's upper gates get equal on-time in each period and are never on together, so the half-level alternates between the two redundant states.
- R8: In each high-frequency pair the two gates are never on together. After one gate turns off, both stay off for g = max(`dead_i`, 1) cycles before the other gate turns on.
- R9: When the sign of the loaded value changes, all four low-frequency gates stay off for g cycles before the other pair turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_i | input | MW | Signed modulation sample, full scale 1.0 = 2**(MW-1) |
| mod_valid_i | input | 1 | Marks mod_i as valid |
| index_i | input | IW | Unsigned modulation index, 1.0 = 2**(IW-1) |
| dead_i | input | DTW | Dead time in clock cycles (minimum effective value 1) |
| lf_gate_o | output | 4 | Low-frequency gates: [1:0] positive pair, [3:2] negative pair |
| hf_gate_o | output | 4 | High-frequency gates: [0]/[1] cell A upper/lower, [2]/[3] cell B upper/lower |
| sample_req_o | output | 1 | One-cycle request at each carrier peak and valley |

## Verification
A wrong duty register, a wrong carrier count or a wrong load decision changes the on-time of the high-frequency gates. The benches count that on-time over one carrier period, so the error shows within one period once the pipeline has settled, which takes two to three cycles after a load. A wrong dead-time counter shows directly at the ports as a missing gap or a gap of the wrong length at the next transition. A sign flag that is stuck or slow shows as the wrong low-frequency pair, or as a missing off interval at the first sign change.

// File: rtl/fivelevel_pkg.sv
package fivelevel_pkg;
  // number of two-level switching cells stacked to reach five levels
  localparam int N_CELL = 2;
  // polarity of the held modulation sample
  typedef enum logic {POL_NEG = 1'b0, POL_POS = 1'b1} pol_e;
endpackage

// File: rtl/fl_carrier.sv
module fl_carrier #(
  parameter int CAR_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  output logic [CAR_BITS:0]   car_o,
  output logic                req_o
);
  localparam int CW = CAR_BITS + 1;
  localparam logic [CW-1:0] CMAX_V = {1'b1, {CAR_BITS{1'b0}}};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_q, up_d;
  logic          req_q;

  always_comb begin
    if (up_q) begin
      cnt_d = cnt_q + 1'b1;
      up_d  = (cnt_d != CMAX_V);
    end else begin
      cnt_d = cnt_q - 1'b1;
      up_d  = (cnt_d == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      req_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      req_q <= (cnt_d == '0) || (cnt_d == CMAX_V);
    end
  end

  assign car_o = cnt_q;
  assign req_o = req_q;
endmodule

// File: rtl/fl_sample.sv
module fl_sample
  import fivelevel_pkg::*;
#(
  parameter int MW       = 16,
  parameter int IW       = 16,
  parameter int CAR_BITS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              valid_i,
  input  logic [MW-1:0]     mod_i,
  input  logic [IW-1:0]     index_i,
  output logic [CAR_BITS:0] duty_o,
  output pol_e              pol_o,
  output logic              armed_o
);
  localparam int CW = CAR_BITS + 1;
  localparam int PW = MW + IW;
  localparam int SH = (MW - 1) + (IW - 1) - CAR_BITS;
  localparam logic [CW-1:0] CMAX_V = {1'b1, {CAR_BITS{1'b0}}};
  localparam logic [PW-1:0] CMAX_P = PW'(CMAX_V);

  logic [MW-1:0] m_q;
  logic          loaded_q;
  logic [MW-1:0] mag;
  logic [PW-1:0] prod, scaled;
  logic [CW-1:0] duty_d;

  always_comb begin
    mag    = m_q[MW-1] ? (~m_q + 1'b1) : m_q;
    prod   = PW'(mag) * PW'(index_i);
    scaled = prod >> SH;
    duty_d = (scaled > CMAX_P) ? CMAX_V : scaled[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q      <= '0;
      loaded_q <= 1'b0;
      duty_o   <= '0;
      pol_o    <= POL_POS;
      armed_o  <= 1'b0;
    end else begin
      if (req_i && valid_i) begin
        m_q      <= mod_i;
        loaded_q <= 1'b1;
      end
      duty_o  <= duty_d;
      pol_o   <= m_q[MW-1] ? POL_NEG : POL_POS;
      armed_o <= loaded_q;
    end
  end
endmodule

// File: rtl/fl_deadband.sv
module fl_deadband #(
  parameter int DTW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_i,
  input  logic           want_i,
  input  logic [DTW-1:0] dt_i,
  output logic           g_hi_o,
  output logic           g_lo_o
);
  logic           side_q;
  logic [DTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      side_q <= 1'b0;
      cnt_q  <= '0;
      g_hi_o <= 1'b0;
      g_lo_o <= 1'b0;
    end else if (!en_i || (want_i != side_q)) begin
      side_q <= want_i;
      cnt_q  <= dt_i;
      g_hi_o <= 1'b0;
      g_lo_o <= 1'b0;
    end else if (cnt_q > DTW'(1)) begin
      cnt_q  <= cnt_q - 1'b1;
      g_hi_o <= 1'b0;
      g_lo_o <= 1'b0;
    end else begin
      cnt_q  <= '0;
      g_hi_o <= side_q;
      g_lo_o <= !side_q;
    end
  end
endmodule

// File: rtl/fivelevel_mod.sv
module fivelevel_mod
  import fivelevel_pkg::*;
#(
  parameter int MW       = 16,
  parameter int IW       = 16,
  parameter int CAR_BITS = 10,
  parameter int DTW      = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [MW-1:0]  mod_i,
  input  logic           mod_valid_i,
  input  logic [IW-1:0]  index_i,
  input  logic [DTW-1:0] dead_i,
  output logic [3:0]     lf_gate_o,
  output logic [3:0]     hf_gate_o,
  output logic           sample_req_o
);
  localparam int CW = CAR_BITS + 1;
  localparam logic [CW-1:0] CMAX_V = {1'b1, {CAR_BITS{1'b0}}};

  logic [CW-1:0] car;
  logic          req;
  logic [CW-1:0] duty;
  pol_e          pol;
  logic          armed;
  logic          lf_hi, lf_lo;

  fl_carrier #(.CAR_BITS(CAR_BITS)) u_car (
    .clk   (clk),
    .rst   (rst),
    .car_o (car),
    .req_o (req)
  );

  fl_sample #(.MW(MW), .IW(IW), .CAR_BITS(CAR_BITS)) u_smp (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req),
    .valid_i (mod_valid_i),
    .mod_i   (mod_i),
    .index_i (index_i),
    .duty_o  (duty),
    .pol_o   (pol),
    .armed_o (armed)
  );

  // one comparator and dead-band per switching cell; cell B sees the mirrored carrier
  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    logic [CW-1:0] ref_car;
    logic          want_q;

    if (c == 0) begin : g_direct
      assign ref_car = car;
    end else begin : g_mirror
      assign ref_car = CMAX_V - car;
    end

    always_ff @(posedge clk) begin
      if (rst) want_q <= 1'b0;
      else     want_q <= (duty == CMAX_V) || (duty > ref_car);
    end

    fl_deadband #(.DTW(DTW)) u_db (
      .clk    (clk),
      .rst    (rst),
      .en_i   (armed),
      .want_i (want_q),
      .dt_i   (dead_i),
      .g_hi_o (hf_gate_o[2*c]),
      .g_lo_o (hf_gate_o[2*c+1])
    );
  end

  fl_deadband #(.DTW(DTW)) u_lf (
    .clk    (clk),
    .rst    (rst),
    .en_i   (armed),
    .want_i (pol == POL_POS),
    .dt_i   (dead_i),
    .g_hi_o (lf_hi),
    .g_lo_o (lf_lo)
  );

  assign lf_gate_o    = {lf_lo, lf_lo, lf_hi, lf_hi};
  assign sample_req_o = req;
endmodule

// File: rtl/fivelevel_mod_chk.sv
module fivelevel_mod_chk (
  input logic       clk,
  input logic       rst,
  input logic       mod_valid_i,
  input logic       sample_req_o,
  input logic [3:0] lf_gate_o,
  input logic [3:0] hf_gate_o
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst)                              seen_q <= 1'b0;
    else if (sample_req_o && mod_valid_i) seen_q <= 1'b1;
  end

  AST_OFF_BEFORE_LOAD: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> (lf_gate_o == 4'b0000) && (hf_gate_o == 4'b0000)); // R1

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sample_req_o |=> !sample_req_o); // R2

  AST_HF_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(hf_gate_o[0] && hf_gate_o[1]) && !(hf_gate_o[2] && hf_gate_o[3])); // R8

  AST_HF_GAP_A: assert property (@(posedge clk) disable iff (rst)
    ($rose(hf_gate_o[1]) |-> !$past(hf_gate_o[0])) and
    ($rose(hf_gate_o[0]) |-> !$past(hf_gate_o[1]))); // R8

  AST_HF_GAP_B: assert property (@(posedge clk) disable iff (rst)
    ($rose(hf_gate_o[3]) |-> !$past(hf_gate_o[2])) and
    ($rose(hf_gate_o[2]) |-> !$past(hf_gate_o[3]))); // R8

  AST_LF_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !((lf_gate_o[1:0] != 2'b00) && (lf_gate_o[3:2] != 2'b00))); // R9

  AST_LF_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(lf_gate_o[2]) |-> ($past(lf_gate_o[1:0]) == 2'b00)) and
    ($rose(lf_gate_o[0]) |-> ($past(lf_gate_o[3:2]) == 2'b00))); // R9
endmodule

bind fivelevel_mod fivelevel_mod_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .mod_valid_i  (mod_valid_i),
  .sample_req_o (sample_req_o),
  .lf_gate_o    (lf_gate_o),
  .hf_gate_o    (hf_gate_o)
);

// File: tb/test_fivelevel_mod.sv
module test_fivelevel_mod;
  localparam int MW = 16, IW = 16, CAR_BITS = 6, DTW = 6;
  localparam int CMAX = 1 << CAR_BITS;
  localparam int PER  = 2 * CMAX;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [MW-1:0]  mod_i = '0;
  logic           mod_valid_i = 1'b0;
  logic [IW-1:0]  index_i = 16'h8000;
  logic [DTW-1:0] dead_i = 6'd3;
  logic [3:0]     lf_gate_o, hf_gate_o;
  logic           sample_req_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fivelevel_mod #(.MW(MW), .IW(IW), .CAR_BITS(CAR_BITS), .DTW(DTW)) i_fivelevel_mod (
    .clk(clk), .rst(rst), .mod_i(mod_i), .mod_valid_i(mod_valid_i),
    .index_i(index_i), .dead_i(dead_i), .lf_gate_o(lf_gate_o),
    .hf_gate_o(hf_gate_o), .sample_req_o(sample_req_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts over exactly one carrier period
  int a_hi, a_lo, b_hi, b_lo, both_up, lf_bad;
  task automatic measure(input logic [3:0] lf_exp);
    a_hi = 0; a_lo = 0; b_hi = 0; b_lo = 0; both_up = 0; lf_bad = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      a_hi += int'(hf_gate_o[0]);
      a_lo += int'(hf_gate_o[1]);
      b_hi += int'(hf_gate_o[2]);
      b_lo += int'(hf_gate_o[3]);
      both_up += int'(hf_gate_o[0] && hf_gate_o[2]);
      lf_bad += int'(lf_gate_o != lf_exp);
    end
  endtask

  task automatic settle();
    repeat (4 * PER) @(negedge clk);
  endtask

  task automatic apply(input logic [MW-1:0] m, input logic [IW-1:0] idx);
    @(negedge clk);
    mod_i = m; index_i = idx; mod_valid_i = 1'b1;
    settle();
  endtask

  function automatic int gap_of(input int dt);
    return (dt < 1) ? 1 : dt;
  endfunction

  task automatic t_reset();
    int nz = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3 * PER; i++) begin
      @(negedge clk);
      nz += int'((lf_gate_o != 4'b0000) || (hf_gate_o != 4'b0000));
    end
    chk(nz == 0, "R1 gates off before first load", nz, 0);
  endtask

  task automatic t_request();
    int last = -1, gap_bad = 0, wide = 0, pulses = 0;
    bit prev = 1'b0;
    for (int i = 0; i < 4 * PER; i++) begin
      @(negedge clk);
      if (sample_req_o) begin
        if (prev) wide++;
        if (last >= 0 && (i - last) != CMAX) gap_bad++;
        last = i;
        pulses++;
      end
      prev = sample_req_o;
    end
    chk(gap_bad == 0 && pulses == 8, "R2 request spacing", pulses, 8);
    chk(wide == 0, "R2 request one cycle wide", wide, 0);
  endtask

  task automatic t_duty();
    int g = gap_of(3);
    apply(16'h3000, 16'h8000); // d = 24
    measure(4'b0011);
    chk(a_hi == 2*24-1-g, "R5 cell A upper on-time d=24", a_hi, 2*24-1-g);
    chk(a_lo == PER-2*24+1-g, "R5 cell A lower on-time d=24", a_lo, PER-2*24+1-g);
    chk(b_hi == 2*24-1-g, "R5 cell B upper on-time d=24", b_hi, 2*24-1-g);
    chk(lf_bad == 0, "R4 positive pair on", lf_bad, 0);
    apply(16'h2000, 16'h4000); // index halves: d = 8
    measure(4'b0011);
    chk(a_hi == 2*8-1-g, "R5 index scaling d=8", a_hi, 2*8-1-g);
  endtask

  task automatic t_alternate();
    apply(16'h1000, 16'h8000); // d = 8
    measure(4'b0011);
    chk(a_hi == b_hi, "R7 equal cell on-time", a_hi, b_hi);
    chk(both_up == 0, "R7 cells never both up", both_up, 0);
  endtask

  task automatic t_saturate();
    apply(16'h7000, 16'hFFFF); // clamps to CMAX
    measure(4'b0011);
    chk(a_hi == PER && b_hi == PER, "R6 saturated upper full", a_hi + b_hi, 2*PER);
    chk(a_lo == 0 && b_lo == 0, "R6 saturated lower off", a_lo + b_lo, 0);
    apply(16'h0000, 16'h8000); // d = 0, counts as positive
    measure(4'b0011);
    chk(a_lo == PER && a_hi == 0, "R6 zero duty lower full", a_lo, PER);
    chk(lf_bad == 0, "R4 zero is positive", lf_bad, 0);
  endtask

  task automatic t_hold();
    int g = gap_of(3);
    apply(16'h3000, 16'h8000);
    @(negedge clk);
    mod_valid_i = 1'b0;
    mod_i = 16'h1000;
    settle();
    measure(4'b0011);
    chk(a_hi == 2*24-1-g, "R3 no load while valid low", a_hi, 2*24-1-g);
    // single valid strobe away from a request
    @(negedge clk);
    while (sample_req_o) @(negedge clk);
    mod_valid_i = 1'b1;
    @(negedge clk);
    mod_valid_i = 1'b0;
    settle();
    measure(4'b0011);
    chk(a_hi == 2*24-1-g, "R3 strobe outside request ignored", a_hi, 2*24-1-g);
    @(negedge clk);
    mod_valid_i = 1'b1;
    settle();
    measure(4'b0011);
    chk(a_hi == 2*8-1-g, "R3 load at request", a_hi, 2*8-1-g);
  endtask

  task automatic t_lf_dead();
    int gap = 0;
    bit reached = 0;
    apply(16'h3000, 16'h8000);
    @(negedge clk);
    mod_i = 16'hD000; // -0.375, d = 24
    for (int i = 0; i < 4 * PER && !reached; i++) begin
      @(negedge clk);
      if (lf_gate_o == 4'b0000) gap++;
      else if (lf_gate_o == 4'b1100) reached = 1;
    end
    chk(reached && gap == 3, "R9 low-frequency dead time", gap, 3);
    settle();
    measure(4'b1100);
    chk(lf_bad == 0, "R4 negative pair on", lf_bad, 0);
    chk(a_hi == 2*24-1-3, "R5 negative value rectified", a_hi, 2*24-1-3);
  endtask

  task automatic t_hf_dead();
    @(negedge clk);
    dead_i = 6'd0;
    apply(16'h3000, 16'h8000);
    measure(4'b0011);
    chk(a_hi == 2*24-1-1, "R8 minimum gap upper", a_hi, 2*24-2);
    chk(a_lo == PER-2*24+1-1, "R8 minimum gap lower", a_lo, PER-2*24);
    @(negedge clk);
    dead_i = 6'd7;
    settle();
    measure(4'b0011);
    chk(a_hi == 2*24-1-7 && b_hi == 2*24-1-7, "R8 dead time seven", a_hi, 2*24-8);
  endtask

  initial begin
    t_reset();
    t_request();
    t_duty();
    t_alternate();
    t_saturate();
    t_hold();
    t_lf_dead();
    t_hf_dead();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule